// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a single-clock synchronous memory with a late write. A command and its address are registered on one rising edge. A read returns its word from an output register after the next working edge. A write takes its data from the bus two working edges after its address. Because the data of a write lags its address by two cycles, a controller can mix reads and writes on every cycle with no idle cycle between them.

A command starts when the load strobe and clock enable are both low on an edge. While the load strobe is high, the core continues the current burst at the next address. A clock enable held high freezes the whole pipeline. A sleep input, which acts two cycles after it changes, also freezes the core and keeps the array intact. An asynchronous output enable decides whether the output word is presented.

Top module: `zt_sram`

## Requirements
- R1: A read started at working edge E (cs_n=0, adv_ld_n=0, we_n=1) loads the output register at the next working edge. rvalid is then high and the word holds the array content at that address.
- R2: A write started at working edge E (cs_n=0, adv_ld_n=0, we_n=0) takes wdata at the second working edge after E. Lane i, bits 8i+7..8i, is written when be_n[i] was low at E. rvalid is low after the edge that follows a write start.
- R3: A write whose four be_n bits are all high at its start leaves the array unchanged.
- R4: A read of an address whose write data arrives at the same edge returns that data merged per lane, so read-after-write is always coherent.
- R5: With adv_ld_n high after a read or write, the core issues the same kind of access at the next address. The next address has its low two bits incremented modulo 4 and its upper bits kept. A burst write takes be_n afresh at each beat.
- R6: cs_n high with adv_ld_n low is a deselect. A following adv_ld_n high keeps the core deselected. rvalid is low after the next working edge.
- R7: While cken_n is high, all inputs except sleep and oe_n are ignored and every pipeline register, the output register and rvalid hold their values.
- R8: oe_n acts without the clock. rdata shows the output register and rdata_oe is high only while oe_n is low and rvalid is high. Otherwise rdata is zero and rdata_oe is low.
- R9: sleep high at edge k leaves edges k and k+1 working. From edge k+2 on, and while sleep stays high, the core holds all its state as in R7. The array is preserved.
- R10: sleep low at edge j keeps the core frozen at edge j+1. Edge j+2 is a working edge again.
- R11: After reset, rvalid and rdata_oe are low, rdata is zero, and no access is pending.
- R12: Reads and writes may alternate on consecutive edges with no idle cycle, and each keeps the timing of R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, sampled with a load |
| adv_ld_n | input | 1 | Low: load a new command; high: continue the burst |
| we_n | input | 1 | Low selects write, high read, at a load |
| be_n | input | 4 | Active-low lane write strobes |
| cken_n | input | 1 | Active-low clock enable |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Active-high sleep request |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data, two working edges after its address |
| rdata | output | 32 | Read word, zero when not presented |
| rdata_oe | output | 1 | High while rdata is presented |
| rvalid | output | 1 | Output register holds the result of a read |

## Verification
The bench aims at the edges where the late write meets a read. A read one cycle after a write to the same address checks the lane merge. A design that read only the array would return the old word there. Partial strobes, a fully masked write and wrapping bursts from a non-aligned start check lane selection and the modulo-4 address step. A design that carried into the upper bits would touch the wrong word. Clock-enable gaps placed inside a write's two-cycle window, and sleep held across pending accesses, check that the data lag counts only working edges. A design that let any stage advance would write the wrong data. Toggling output enable in the middle of a cycle shows whether the output gate is truly asynchronous.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               adv_ld_n,
  input  logic               we_n,
  input  logic [LANES-1:0]   be_n,
  input  logic               cken_n,
  input  logic               oe_n,
  input  logic               sleep,
  input  logic [AW-1:0]      addr,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata,
  output logic               rdata_oe,
  output logic               rvalid
);
  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {K_IDLE, K_RD, K_WR} kind_t;

  logic [DW-1:0]    mem [DEPTH];
  logic             slp1, slp2;
  kind_t            bkind, nkind;
  logic [AW-1:0]    baddr, naddr, a1, a2;
  logic             rd1, wr1, wr2, rv_q;
  logic [LANES-1:0] be1, be2;
  logic [DW-1:0]    dout_q, fwd;

  wire run = !cken_n && !slp2;

  always_comb begin
    nkind = bkind;
    naddr = baddr;
    if (!adv_ld_n) begin
      nkind = cs_n ? K_IDLE : (we_n ? K_RD : K_WR);
      if (!cs_n) naddr = addr;
    end else if (bkind != K_IDLE) begin
      naddr = {baddr[AW-1:2], baddr[1:0] + 2'd1};
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd[8*l +: 8] = (wr2 && be2[l] && a2 == a1) ? wdata[8*l +: 8] : mem[a1][8*l +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp1 <= 1'b0;
      slp2 <= 1'b0;
    end else begin
      slp1 <= sleep;
      slp2 <= slp1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bkind  <= K_IDLE;
      baddr  <= '0;
      rd1    <= 1'b0;
      wr1    <= 1'b0;
      wr2    <= 1'b0;
      a1     <= '0;
      a2     <= '0;
      be1    <= '0;
      be2    <= '0;
      rv_q   <= 1'b0;
      dout_q <= '0;
    end else if (run) begin
      bkind <= nkind;
      baddr <= naddr;
      rd1   <= (nkind == K_RD);
      wr1   <= (nkind == K_WR);
      a1    <= naddr;
      be1   <= ~be_n;
      wr2   <= wr1;
      a2    <= a1;
      be2   <= be1;
      rv_q  <= rd1;
      if (rd1) dout_q <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (run && wr2)
      for (int l = 0; l < LANES; l++)
        if (be2[l]) mem[a2][8*l +: 8] <= wdata[8*l +: 8];
  end

  assign rvalid   = rv_q;
  assign rdata_oe = rv_q && !oe_n;
  assign rdata    = rdata_oe ? dout_q : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          adv_ld_n,
  input logic          we_n,
  input logic          cken_n,
  input logic          oe_n,
  input logic          asleep,
  input logic          rvalid,
  input logic          rdata_oe,
  input logic [DW-1:0] dout_q
);
  AST_HOLD_ON_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    cken_n |=> ($stable(rvalid) && $stable(dout_q))); // R7

  AST_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> ($stable(rvalid) && $stable(dout_q))); // R9

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !asleep && !adv_ld_n && !cs_n && we_n) ##1 (!cken_n && !asleep) |=> rvalid); // R1

  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !asleep && !adv_ld_n && !cs_n && !we_n) ##1 (!cken_n && !asleep) |=> !rvalid); // R2

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !asleep && !adv_ld_n && cs_n) ##1 (!cken_n && !asleep) |=> !rvalid); // R6

  AST_OE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (rvalid && !oe_n)); // R8
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_ld_n(adv_ld_n), .we_n(we_n),
  .cken_n(cken_n), .oe_n(oe_n), .asleep(slp2), .rvalid(rvalid),
  .rdata_oe(rdata_oe), .dout_q(dout_q)
);

// File: tb/zt_sram_tb_top.sv
module zt_sram_tb_top;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, adv_ld_n = 0, we_n = 1, cken_n = 0, oe_n = 0, sleep = 0;
  logic [3:0] be_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rdata_oe, rvalid;

  zt_sram #(.AW(AW), .LANES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_ld_n(adv_ld_n), .we_n(we_n),
    .be_n(be_n), .cken_n(cken_n), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .rvalid(rvalid)
  );

  always #10 clk = ~clk;

  typedef struct { bit rd; bit wr; int a; bit [3:0] be; } op_t;
  op_t pq[$];
  logic [31:0] mm [DEPTH];
  logic [31:0] datq[$];
  logic [31:0] m_q;
  bit m_rv, ms1, ms2;
  int bkind, baddr;
  int checks = 0, fails = 0;
  string tag = "R11";
  bit done = 0;

  function automatic logic [31:0] pat(int a, int s);
    return 32'h5A00_0000 ^ (a * 32'h0103_0507) ^ (s * 32'h1F00_0F1F);
  endfunction

  task automatic model_reset();
    op_t idle = '{0, 0, 0, 4'h0};
    pq = {}; pq.push_back(idle); pq.push_back(idle);
    datq = {}; datq.push_back('0); datq.push_back('0);
    ms1 = 0; ms2 = 0; m_rv = 0; m_q = '0; bkind = 0; baddr = 0;
  endtask

  task automatic model_edge();
    bit slp = ms2;
    ms2 = ms1; ms1 = sleep;
    if (!slp && !cken_n) begin
      op_t o0 = pq[0], o1 = pq[1], n;
      if (o0.wr)
        for (int l = 0; l < 4; l++) if (o0.be[l]) mm[o0.a][8*l +: 8] = wdata[8*l +: 8];
      m_rv = o1.rd;
      if (o1.rd) m_q = mm[o1.a];
      void'(pq.pop_front());
      if (!adv_ld_n) begin
        if (!cs_n) begin bkind = we_n ? 1 : 2; baddr = int'(addr); end
        else bkind = 0;
      end else if (bkind != 0) begin
        baddr = (baddr & ~3) | ((baddr + 1) & 3);
      end
      n.rd = (bkind == 1); n.wr = (bkind == 2); n.a = baddr; n.be = ~be_n;
      pq.push_back(n);
    end
  endtask

  task automatic compare();
    bit eoe = !oe_n && m_rv;
    logic [31:0] ed = eoe ? m_q : '0;
    checks++;
    if (rvalid !== m_rv || rdata_oe !== eoe || rdata !== ed) begin
      fails++;
      $display("FAIL %s: rvalid=%0b rdata_oe=%0b rdata=%h, expected rvalid=%0b rdata_oe=%0b rdata=%h",
               tag, rvalid, rdata_oe, rdata, m_rv, eoe, ed);
    end
  endtask

  task automatic step(bit c, bit adv, bit we, logic [3:0] bw, int a, logic [31:0] d,
                      bit ck = 0, bit sl = 0);
    bit run_b = !ck && !ms2;
    cs_n = c; adv_ld_n = adv; we_n = we; be_n = bw; addr = a[AW-1:0];
    cken_n = ck; sleep = sl; wdata = datq[0];
    @(posedge clk);
    model_edge();
    if (run_b) begin void'(datq.pop_front()); datq.push_back(d); end
    @(negedge clk);
    compare();
  endtask

  task automatic rd(int a);                          step(0, 0, 1, 4'hF, a, '0); endtask
  task automatic wr(int a, logic [31:0] d, logic [3:0] bw = 4'h0); step(0, 0, 0, bw, a, d); endtask
  task automatic desel();                            step(1, 0, 1, 4'hF, 0, '0); endtask
  task automatic flush(); repeat (3) desel(); endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    tag = "R11";
    compare();
    checks++;
    if (rvalid !== 1'b0 || rdata_oe !== 1'b0 || rdata !== '0) begin
      fails++;
      $display("FAIL R11: rvalid=%0b rdata=%h, expected 0 and 0", rvalid, rdata);
    end
    rst_n = 1;
    desel();

    tag = "R2";
    for (int i = 0; i < DEPTH; i++) wr(i, pat(i, 0));
    flush();

    tag = "R1";
    for (int i = 0; i < 8; i++) rd(i * 7 % DEPTH);
    flush();

    tag = "R12";
    for (int i = 0; i < 10; i++) begin
      if (i % 2 == 0) wr(10 + i, pat(10 + i, 1)); else rd(10 + i - 1);
    end
    flush();
    for (int i = 0; i < 6; i++) rd(10 + 2 * i);
    flush();

    tag = "R4";
    wr(20, pat(20, 2), 4'b0101); rd(20);
    wr(21, pat(21, 2)); desel(); rd(21);
    wr(22, pat(22, 2), 4'b1000); rd(22); rd(22);
    flush();

    tag = "R3";
    wr(23, pat(23, 3), 4'hF); desel(); rd(23);
    flush();

    tag = "R5";
    rd(6); step(0, 1, 1, 4'hF, 0, '0); step(1, 1, 0, 4'h0, 0, '0); step(0, 1, 1, 4'hF, 0, '0);
    step(0, 1, 1, 4'hF, 0, '0);
    desel();
    wr(41, pat(41, 4)); step(1, 1, 1, 4'b0011, 0, pat(42, 4));
    step(1, 1, 1, 4'h0, 0, pat(43, 4)); step(1, 1, 1, 4'hF, 0, pat(40, 4));
    desel(); desel();
    for (int i = 40; i < 44; i++) rd(i);
    flush();

    tag = "R6";
    rd(30); desel(); step(0, 1, 1, 4'hF, 31, '0); step(0, 1, 0, 4'h0, 31, '0);
    desel(); rd(31);
    flush();

    tag = "R7";
    wr(50, pat(50, 5)); step(0, 0, 1, 4'hF, 51, '0, 1); step(1, 1, 1, 4'hF, 0, '0, 1);
    desel(); desel(); rd(50);
    rd(51); step(0, 0, 0, 4'h0, 52, pat(0, 9), 1); step(0, 0, 0, 4'h0, 53, '0, 1);
    desel(); desel(); rd(52); rd(53);
    flush();

    tag = "R8";
    rd(12); desel();
    oe_n = 1; #1; checks++;
    if (rdata !== '0 || rdata_oe !== 1'b0) begin
      fails++; $display("FAIL R8: rdata=%h oe=%0b, expected 0 and 0", rdata, rdata_oe);
    end
    #3 oe_n = 0; #1; checks++;
    if (rdata !== mm[12] || rdata_oe !== 1'b1) begin
      fails++; $display("FAIL R8: rdata=%h, expected %h", rdata, mm[12]);
    end
    oe_n = 1; desel(); rd(13); oe_n = 0; desel();
    flush();

    tag = "R9";
    wr(60, pat(60, 6)); step(0, 0, 1, 4'hF, 61, '0, 0, 1);
    step(0, 0, 0, 4'h0, 62, '0, 0, 1);
    step(0, 0, 0, 4'h0, 63, pat(1, 9), 0, 1); step(0, 0, 1, 4'hF, 5, '0, 0, 1);
    tag = "R10";
    step(1, 0, 1, 4'hF, 0, '0, 0, 0); step(0, 0, 1, 4'hF, 60, '0, 0, 0);
    rd(62); rd(63); rd(5);
    flush();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule